// File: doc/BRIEF.md
# Two-Way Cache Tag and Control Engine with Way Locking

This block holds the tags and line states of a two-way set-associative data cache. It also steers the cache's data storage and the refill traffic. A requester presents one access at a time. The set is selected by an index that comes from the virtual address. The stored tags are compared with a tag that comes from the physical address. The block answers with a hit or miss response. On a miss it picks a victim way, writes back a dirty victim, and refills the line over a one-beat-at-a-time memory port.

Each way can be locked, which removes it from replacement but still lets it hit. Every access carries its own write-policy bit, taken from its page attribute: write-back or write-through. On a refill the first beat fetched is the doubleword the requester asked for. The response is released on that beat while the rest of the line streams in behind it.

Top module: `lockway_cache_ctrl`

## Requirements
- R1: An access hits when a valid way of the set selected by `req_index` holds a tag equal to `req_tag`. A read hit answers with `resp_hit`=1 and the stored doubleword at `req_word`. At most one way of a set can hit.
- R2: `req_ready` is high only while the block is idle, and it falls in the cycle after an access is accepted. Every accepted access produces exactly one single-cycle `resp_valid` pulse.
- R3: With no way locked, the victim is the way of the set that was not most recently hit or filled, tracked by one bit per set. After reset, way 0 is the first victim of every set.
- R4: A locked way (`lock_way[w]`=1) is never chosen as a victim. With exactly one way locked, the other way is always the victim. A locked way still hits.
- R5: When both ways are locked, a miss makes one uncached memory beat at the access address and allocates nothing. A read miss returns the memory doubleword with `resp_hit`=0.
- R6: A write-back store (`req_wt`=0) that hits updates the stored doubleword, marks the line dirty and makes no memory traffic.
- R7: A write-through store (`req_wt`=1) that hits updates the stored doubleword and makes one memory write beat carrying the store data. It answers with `resp_hit`=1.
- R8: A write-through store that misses makes one memory write beat and does not allocate a line.
- R9: Replacing a valid dirty victim first writes back its whole line, at the victim's old tag, with word offsets in ascending order from 0. All of these beats come before any refill beat.
- R10: A refill fetches the line with word offsets wrapping upward from `req_word`. The response is released on the first beat, while later beats are still pending. A read takes that beat's data. A write-back store that misses allocates, merges its data into the line and leaves the line dirty.
- R11: A memory beat completes on a clock edge where `mem_valid` and `mem_ack` are both high. Until then, `mem_addr`, `mem_we` and `mem_wdata` stay stable. `mem_addr` is {tag, index, word offset}, with the tag in the upper bits.
- R12: After reset `req_ready`=1, `resp_valid`=0, `mem_valid`=0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_way | input | 2 | Per-way replacement lock |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | Page write policy: 1 = write-through |
| req_index | input | IDX_W | Set index (virtual) |
| req_tag | input | TAG_W | Tag (physical) |
| req_word | input | WORD_W | Doubleword offset in the line |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Block idle, access accepted when valid |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Access hit the cache |
| resp_rdata | output | DATA_W | Load data, zero for stores |
| mem_valid | output | 1 | Memory beat pending |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | TAG_W+IDX_W+WORD_W | Beat doubleword address |
| mem_wdata | output | DATA_W | Beat write data |
| mem_ack | input | 1 | Memory takes or returns the beat |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
The bench drives a victim sequence with a dirty line that must be written back before a wrapped refill. A controller that refilled first, or wrote back in the wrong word order, would give mismatched memory beats. Lock patterns check that a locked way is never evicted and still hits. With both ways locked, the bench expects no allocation, so a design that allocated there would turn the repeated access into a hit. The bench also checks that the refill response comes while refill beats are still pending, which catches a design that waits for the whole line. Write-through misses are followed by reads that must miss, and a long pseudo-random mix of policies, locks and addresses exercises the LRU bit against an independent model.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB_RD,
    ST_WB_SEND,
    ST_FILL,
    ST_SINGLE
  } lkc_state_e;
endpackage

// File: rtl/lkc_way_ram.sv
module lkc_way_ram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  // simple dual-port, registered read
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/lkc_tag_store.sv
module lkc_tag_store #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      idx,
  input  logic [TAG_W-1:0]      cmp_tag,
  output logic [1:0]            hit_o,
  output logic [1:0][TAG_W-1:0] tag_o,
  output logic [1:0]            valid_o,
  output logic [1:0]            dirty_o,
  output logic                  lru_o,
  input  logic                  fill_we,
  input  logic                  fill_way,
  input  logic                  fill_dirty,
  input  logic                  dirty_set,
  input  logic                  dirty_way,
  input  logic                  lru_we,
  input  logic                  lru_val
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  vld;
    logic [SETS-1:0]  drt;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld <= '0;
        drt <= '0;
      end else if (fill_we && fill_way == 1'(w)) begin
        tags[idx] <= cmp_tag;
        vld[idx]  <= 1'b1;
        drt[idx]  <= fill_dirty;
      end else if (dirty_set && dirty_way == 1'(w)) begin
        drt[idx]  <= 1'b1;
      end
    end

    assign tag_o[w]   = tags[idx];
    assign valid_o[w] = vld[idx];
    assign dirty_o[w] = drt[idx];
    assign hit_o[w]   = vld[idx] && (tags[idx] == cmp_tag);
  end

  // one bit per set naming the next victim way
  logic [SETS-1:0] lru_q;
  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else if (lru_we) lru_q[idx] <= lru_val;
  end
  assign lru_o = lru_q[idx];

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_o)); // R1
endmodule

// File: rtl/lkc_victim_pick.sv
module lkc_victim_pick (
  input  logic [1:0] lock,
  input  logic       lru,
  output logic       vway,
  output logic       none_free
);
  always_comb begin
    none_free = &lock;
    if (lock[0])      vway = 1'b1;
    else if (lock[1]) vway = 1'b0;
    else              vway = lru;
  end
endmodule

// File: rtl/lockway_cache_ctrl.sv
module lockway_cache_ctrl #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 8,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    lock_way,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic                          req_wt,
  input  logic [IDX_W-1:0]              req_index,
  input  logic [TAG_W-1:0]              req_tag,
  input  logic [WORD_W-1:0]             req_word,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          req_ready,
  output logic                          resp_valid,
  output logic                          resp_hit,
  output logic [DATA_W-1:0]             resp_rdata,
  output logic                          mem_valid,
  output logic                          mem_we,
  output logic [TAG_W+IDX_W+WORD_W-1:0] mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic                          mem_ack,
  input  logic [DATA_W-1:0]             mem_rdata
);
  import lkc_pkg::*;

  localparam int RAM_AW = IDX_W + WORD_W;
  localparam logic [WORD_W-1:0] LAST_WORD = '1;

  lkc_state_e state_q, state_d;

  logic              r_write, r_wt, r_hit, r_way, r_first;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag, r_old_tag;
  logic [WORD_W-1:0] r_word, r_cnt;
  logic [DATA_W-1:0] r_wdata;

  logic [1:0]              hit;
  logic [1:0][TAG_W-1:0]   tag_rd;
  logic [1:0]              valid_rd, dirty_rd;
  logic                    lru_rd, vway, none_free, hway, beat;
  logic                    fill_we, dirty_set, lru_we, lru_val;
  logic [1:0]              ram_we;
  logic [RAM_AW-1:0]       ram_waddr, ram_raddr;
  logic [DATA_W-1:0]       ram_wdata;
  logic [1:0][DATA_W-1:0]  ram_rd;
  logic [WORD_W-1:0]       fill_word;

  lkc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(r_idx), .cmp_tag(r_tag),
    .hit_o(hit), .tag_o(tag_rd), .valid_o(valid_rd), .dirty_o(dirty_rd),
    .lru_o(lru_rd), .fill_we(fill_we), .fill_way(r_way), .fill_dirty(r_write),
    .dirty_set(dirty_set), .dirty_way(hway), .lru_we(lru_we), .lru_val(lru_val)
  );

  lkc_victim_pick u_vic (
    .lock(lock_way), .lru(lru_rd), .vway(vway), .none_free(none_free)
  );

  for (genvar w = 0; w < 2; w++) begin : g_ram
    lkc_way_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
      .clk(clk), .we(ram_we[w]), .waddr(ram_waddr), .wdata(ram_wdata),
      .raddr(ram_raddr), .rdata(ram_rd[w])
    );
  end

  assign hway      = hit[1];
  assign beat      = mem_valid && mem_ack;
  assign fill_word = r_word + r_cnt;
  assign req_ready = (state_q == ST_IDLE);
  assign ram_raddr = (state_q == ST_IDLE) ? {req_index, req_word} : {r_idx, r_cnt};

  assign mem_valid = (state_q == ST_WB_SEND) || (state_q == ST_FILL) || (state_q == ST_SINGLE);
  assign mem_we    = (state_q == ST_WB_SEND) || (state_q == ST_SINGLE && r_write);
  assign mem_wdata = (state_q == ST_WB_SEND) ? ram_rd[r_way] : r_wdata;

  always_comb begin
    case (state_q)
      ST_WB_SEND: mem_addr = {r_old_tag, r_idx, r_cnt};
      ST_FILL:    mem_addr = {r_tag, r_idx, fill_word};
      default:    mem_addr = {r_tag, r_idx, r_word};
    endcase
  end

  always_comb begin
    state_d   = state_q;
    fill_we   = 1'b0;
    dirty_set = 1'b0;
    lru_we    = 1'b0;
    lru_val   = 1'b0;
    ram_we    = 2'b00;
    ram_waddr = {r_idx, r_word};
    ram_wdata = r_wdata;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_LOOK;
      ST_LOOK: begin
        if (|hit) begin
          lru_we  = 1'b1;
          lru_val = ~hway;
          if (r_write) begin
            ram_we[hway] = 1'b1;
            if (r_wt) state_d = ST_SINGLE;
            else begin
              dirty_set = 1'b1;
              state_d   = ST_IDLE;
            end
          end else begin
            state_d = ST_IDLE;
          end
        end else if (none_free || (r_write && r_wt)) begin
          state_d = ST_SINGLE;
        end else if (valid_rd[vway] && dirty_rd[vway]) begin
          state_d = ST_WB_RD;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WB_RD: state_d = ST_WB_SEND;
      ST_WB_SEND: if (beat) state_d = (r_cnt == LAST_WORD) ? ST_FILL : ST_WB_RD;
      ST_FILL: begin
        if (beat) begin
          ram_we[r_way] = 1'b1;
          ram_waddr     = {r_idx, fill_word};
          ram_wdata     = (r_write && r_first) ? r_wdata : mem_rdata;
          if (r_cnt == LAST_WORD) begin
            fill_we = 1'b1;
            lru_we  = 1'b1;
            lru_val = ~r_way;
            state_d = ST_IDLE;
          end
        end
      end
      ST_SINGLE: if (beat) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      r_write    <= 1'b0;
      r_wt       <= 1'b0;
      r_hit      <= 1'b0;
      r_way      <= 1'b0;
      r_first    <= 1'b0;
      r_idx      <= '0;
      r_tag      <= '0;
      r_old_tag  <= '0;
      r_word     <= '0;
      r_cnt      <= '0;
      r_wdata    <= '0;
    end else begin
      state_q    <= state_d;
      resp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          r_write <= req_write;
          r_wt    <= req_wt;
          r_idx   <= req_index;
          r_tag   <= req_tag;
          r_word  <= req_word;
          r_wdata <= req_wdata;
        end
        ST_LOOK: begin
          if (|hit) begin
            r_way <= hway;
            r_hit <= 1'b1;
            if (!(r_write && r_wt)) begin
              resp_valid <= 1'b1;
              resp_hit   <= 1'b1;
              resp_rdata <= r_write ? '0 : ram_rd[hway];
            end
          end else begin
            r_hit     <= 1'b0;
            r_way     <= vway;
            r_old_tag <= tag_rd[vway];
            r_cnt     <= '0;
            r_first   <= 1'b1;
          end
        end
        ST_WB_SEND: if (beat) r_cnt <= WORD_W'(r_cnt + 1'b1);
        ST_FILL: if (beat) begin
          r_cnt   <= WORD_W'(r_cnt + 1'b1);
          r_first <= 1'b0;
          if (r_first) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_rdata <= r_write ? '0 : mem_rdata;
          end
        end
        ST_SINGLE: if (beat) begin
          resp_valid <= 1'b1;
          resp_hit   <= r_hit;
          resp_rdata <= r_write ? '0 : mem_rdata;
        end
        default: ;
      endcase
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_ONE_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R2
  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && (state_d == ST_FILL || state_d == ST_WB_RD)) |-> !lock_way[vway]); // R4
  AST_BOTH_LOCKED_UNCACHED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && hit == 2'b00 && lock_way == 2'b11) |=> state_q == ST_SINGLE); // R5
  AST_WT_MISS_NOALLOC: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOK && hit == 2'b00 && r_write && r_wt) |=> state_q == ST_SINGLE); // R8
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11
endmodule

// File: tb/sim_lockway_cache_ctrl.sv
`timescale 1ns/1ps
module sim_lockway_cache_ctrl;
  localparam int IDX_W = 2, TAG_W = 8, WORD_W = 2, DATA_W = 32;
  localparam int AW = TAG_W + IDX_W + WORD_W;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] lock_way = 2'b00;
  logic req_valid = 1'b0, req_write = 1'b0, req_wt = 1'b0;
  logic [IDX_W-1:0] req_index = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [WORD_W-1:0] req_word = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, resp_valid, resp_hit, mem_valid, mem_we;
  logic [DATA_W-1:0] resp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  always #2 clk = ~clk;

  lockway_cache_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .lock_way(lock_way), .req_valid(req_valid), .req_write(req_write),
    .req_wt(req_wt), .req_index(req_index), .req_tag(req_tag), .req_word(req_word),
    .req_wdata(req_wdata), .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_rdata(resp_rdata), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  typedef struct packed {logic hit; logic chk; logic early; logic [31:0] data; logic [7:0] rq;} rsp_t;
  typedef struct packed {logic we; logic [AW-1:0] addr; logic [31:0] data; logic [7:0] rq;} beat_t;
  rsp_t  rsp_q[$];
  beat_t beat_q[$];
  int n_chk = 0, n_bad = 0;

  // independent reference state
  logic [TAG_W-1:0] m_tag [2][4];
  bit               m_val [2][4];
  bit               m_dirty [2][4];
  bit               m_lru [4];
  logic [31:0]      m_data [2][4][4];
  logic [31:0]      bmem [1 << AW];

  function automatic logic [AW-1:0] mk(int t, int i, int w);
    return {TAG_W'(t), IDX_W'(i), WORD_W'(w)};
  endfunction

  task automatic fail_line(string what, int rq, logic [63:0] act, logic [63:0] exp);
    n_bad++;
    $display("FAIL R%0d %s actual %h expected %h", rq, what, act, exp);
  endtask

  task automatic push_beat(bit we, logic [AW-1:0] a, logic [31:0] d, int rq);
    beat_t b;
    b.we = we; b.addr = a; b.data = d; b.rq = 8'(rq);
    beat_q.push_back(b);
  endtask

  task automatic access(bit wr, bit wt, int idx, int tg, int wd, logic [31:0] wdat, int rq);
    bit h0, h1;
    int hw, v;
    rsp_t r;
    logic [AW-1:0] a;
    h0 = m_val[0][idx] && (m_tag[0][idx] == TAG_W'(tg));
    h1 = m_val[1][idx] && (m_tag[1][idx] == TAG_W'(tg));
    r = '0;
    r.rq = 8'(rq);
    a = mk(tg, idx, wd);
    if (h0 || h1) begin
      hw = h1 ? 1 : 0;
      m_lru[idx] = (hw == 0);
      r.hit = 1'b1;
      if (!wr) begin
        r.chk = 1'b1;
        r.data = m_data[hw][idx][wd];
      end else begin
        m_data[hw][idx][wd] = wdat;
        if (wt) begin
          push_beat(1'b1, a, wdat, rq);
          bmem[a] = wdat;
        end else m_dirty[hw][idx] = 1'b1;
      end
    end else if (lock_way == 2'b11 || (wr && wt)) begin
      if (wr) begin
        push_beat(1'b1, a, wdat, rq);
        bmem[a] = wdat;
      end else begin
        push_beat(1'b0, a, '0, rq);
        r.chk = 1'b1;
        r.data = bmem[a];
      end
    end else begin
      v = lock_way[0] ? 1 : (lock_way[1] ? 0 : int'(m_lru[idx]));
      if (m_val[v][idx] && m_dirty[v][idx]) begin
        for (int k = 0; k < 4; k++) begin
          logic [AW-1:0] wa;
          wa = mk(int'(m_tag[v][idx]), idx, k);
          push_beat(1'b1, wa, m_data[v][idx][k], rq);
          bmem[wa] = m_data[v][idx][k];
        end
      end
      r.early = 1'b1;
      if (!wr) begin
        r.chk = 1'b1;
        r.data = bmem[a];
      end
      for (int i = 0; i < 4; i++) begin
        int k;
        k = (wd + i) % 4;
        push_beat(1'b0, mk(tg, idx, k), '0, rq);
        m_data[v][idx][k] = (wr && i == 0) ? wdat : bmem[mk(tg, idx, k)];
      end
      m_tag[v][idx] = TAG_W'(tg);
      m_val[v][idx] = 1'b1;
      m_dirty[v][idx] = wr;
      m_lru[idx] = (v == 0);
    end
    rsp_q.push_back(r);
    // drive
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wt = wt;
    req_index = IDX_W'(idx); req_tag = TAG_W'(tg); req_word = WORD_W'(wd); req_wdata = wdat;
    @(negedge clk);
    req_valid = 1'b0;
    while (!(req_ready && rsp_q.size() == 0 && beat_q.size() == 0)) @(negedge clk);
  endtask

  // response monitor
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      rsp_t e;
      n_chk++;
      if (rsp_q.size() == 0) fail_line("unexpected response", 2, 64'(resp_hit), 64'(0));
      else begin
        e = rsp_q.pop_front();
        if (resp_hit !== e.hit) fail_line("resp_hit", int'(e.rq), 64'(resp_hit), 64'(e.hit));
        if (e.chk && resp_rdata !== e.data) fail_line("resp_rdata", int'(e.rq), 64'(resp_rdata), 64'(e.data));
        if (e.early) begin
          n_chk++;
          // R10: released on the critical beat while the refill is still running
          if (mem_valid !== 1'b1) fail_line("early release, mem_valid", 10, 64'(mem_valid), 64'(1));
        end
      end
    end
  end

  // memory model and beat scoreboard (R11: one stall cycle before each ack)
  bit stall = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      stall = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_valid) begin
      if (!stall) stall = 1'b1;
      else begin
        beat_t e;
        stall = 1'b0;
        mem_ack = 1'b1;
        mem_rdata = bmem[mem_addr];
        n_chk++;
        if (beat_q.size() == 0) fail_line("unexpected memory beat", 11, 64'(mem_addr), 64'(0));
        else begin
          e = beat_q.pop_front();
          if (mem_we !== e.we || mem_addr !== e.addr)
            fail_line("beat we/addr", int'(e.rq), {51'(0), mem_we, mem_addr}, {51'(0), e.we, e.addr});
          else if (e.we && mem_wdata !== e.data)
            fail_line("beat wdata", int'(e.rq), 64'(mem_wdata), 64'(e.data));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int a = 0; a < (1 << AW); a++) bmem[a] = 32'h5A00_0000 ^ (32'(a) * 32'h0001_0011);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++) begin
        m_val[w][s] = 1'b0; m_dirty[w][s] = 1'b0; m_tag[w][s] = '0;
      end
    for (int s = 0; s < 4; s++) m_lru[s] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    n_chk++; if (req_ready !== 1'b1) fail_line("req_ready after reset", 12, 64'(req_ready), 64'(1));
    n_chk++; if (resp_valid !== 1'b0) fail_line("resp_valid after reset", 12, 64'(resp_valid), 64'(0));
    n_chk++; if (mem_valid !== 1'b0) fail_line("mem_valid after reset", 12, 64'(mem_valid), 64'(0));

    access(0, 0, 1, 'h10, 2, 0, 10);           // R12 all invalid, R10 wrap 2,3,0,1, R3 way 0 first
    access(0, 0, 1, 'h10, 0, 0, 1);            // R1 read hit
    access(0, 0, 1, 'h20, 1, 0, 3);            // R3 second line goes to way 1
    access(0, 0, 1, 'h10, 3, 0, 1);            // R1 hit, way 1 becomes victim
    access(0, 0, 1, 'h30, 0, 0, 3);            // R3 replaces way 1
    access(1, 0, 1, 'h30, 3, 32'hCAFE_0001, 6); // R6 write-back hit, no traffic
    access(0, 0, 1, 'h30, 3, 0, 6);            // R6 data updated
    access(0, 0, 1, 'h40, 2, 0, 3);            // R3 clean victim way 0
    access(0, 0, 1, 'h50, 1, 0, 9);            // R9 dirty way 1 written back before refill
    access(1, 1, 1, 'h50, 2, 32'hBEEF_0002, 7); // R7 write-through hit
    access(0, 0, 1, 'h50, 2, 0, 7);
    access(1, 1, 1, 'h60, 0, 32'h1234_0003, 8); // R8 write-through miss
    access(0, 0, 1, 'h60, 0, 0, 8);            // R8 must miss, memory holds store data
    lock_way = 2'b01;                          // R4 way 0 locked
    access(0, 0, 2, 'h01, 0, 0, 4);
    access(0, 0, 2, 'h02, 1, 0, 4);
    access(0, 0, 2, 'h01, 2, 0, 4);
    lock_way = 2'b10;                          // R4 way 1 locked
    access(0, 0, 2, 'h03, 3, 0, 4);
    access(0, 0, 2, 'h01, 0, 0, 4);            // R4 locked way 1 still hits
    lock_way = 2'b11;                          // R5 both locked
    access(0, 0, 2, 'h09, 1, 0, 5);
    access(0, 0, 2, 'h09, 1, 0, 5);            // R5 no allocation: misses again
    access(1, 0, 2, 'h09, 2, 32'h7777_0004, 5);
    access(0, 0, 2, 'h03, 3, 0, 4);            // R4 locked hit
    lock_way = 2'b00;
    access(1, 0, 3, 'h70, 1, 32'hD00D_0005, 10); // R10 write-back miss allocates and merges
    access(0, 0, 3, 'h70, 1, 0, 10);
    access(0, 0, 3, 'h71, 0, 0, 9);
    access(0, 0, 3, 'h72, 0, 0, 9);            // R9 evicts dirty merged line

    seed = 32'h1357_9BDF;
    for (int i = 0; i < 120; i++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      lock_way = (seed[7:4] == 4'hF) ? 2'b11 : ((seed[6:5] == 2'b00) ? {1'b0, seed[8]} : 2'b00);
      access(int'(seed[0]), int'(seed[1]), int'(seed[11:10]), 'h11 + int'(seed[13:12]),
             int'(seed[15:14]), seed ^ 32'hA5A5_0000, 3); // R3 mixed traffic
    end
    lock_way = 2'b00;
    repeat (5) @(negedge clk);
    n_chk++;
    if (rsp_q.size() != 0 || beat_q.size() != 0)
      fail_line("leftover expectations", 2, 64'(rsp_q.size()), 64'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule